// File: doc/BRIEF.md
# DMA Count and Target Address Register

This block holds the setup state a DMA engine needs before it starts moving words: a transfer count, a direction flag, an enable flag and a word-aligned target address. The CPU loads all of it through an ordinary register write port. The count, direction and enable arrive together in one data word. Loading the count also schedules one dummy transfer, which shows up as a single increment of the stored count on the following clock.

The target address is not taken from the data bus. Software writes to the address register twice, and the bus address lines carry the payload. Address line 14 chooses which half is loaded: the upper field (target bits 21:9) or the lower field (target bits 8:1). The data word of such a write is ignored. The address register cannot be read back, and a read of it returns all ones. The count register reads back with its two top bits forced high. The engine that performs transfers sits outside this block and only consumes its outputs.

Top module: `dma_xfer_regs`

## Requirements
- R1: After reset, dma_count, dma_dir, dma_en and dma_addr are all zero.
- R2: A write with bus_sel_cnt high updates the outputs on the next clock edge: dma_count takes bus_wdata[13:0], dma_dir takes bus_wdata[14] and dma_en takes bus_wdata[15].
- R3: One clock after a count load, dma_count rises by one modulo 2^14, so 0x3FFF becomes 0x0000. It then holds until the next count load.
- R4: A count write in the cycle right after another count write loads the new value, and the increment still pending from the first write is dropped. The new value is incremented one clock later, exactly once.
- R5: While bus_sel_cnt is high, bus_rdata is {2'b11, dma_count} in the same cycle, with no clock in between.
- R6: A write with bus_sel_adr high and bus_addr[14] = 1 loads bus_addr[13:1] into dma_addr[21:9] and leaves dma_addr[8:0] unchanged. bus_wdata has no effect on dma_addr or on dma_count.
- R7: A write with bus_sel_adr high and bus_addr[14] = 0 loads bus_addr[8:1] into dma_addr[8:1] and leaves dma_addr[21:9] unchanged. dma_addr changes only on an address write.
- R8: dma_addr[0] is always zero.
- R9: When bus_sel_cnt is low, bus_rdata is 0xFFFF. This includes a read of the address register. A read (bus_wr low) changes neither dma_count nor dma_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | 1 = write cycle, 0 = read |
| bus_sel_cnt | input | 1 | Selects the count/control register |
| bus_sel_adr | input | 1 | Selects the target address register |
| bus_addr | input | 14 | CPU word address lines 14:1 |
| bus_wdata | input | 16 | CPU write data |
| bus_rdata | output | 16 | CPU read data |
| dma_count | output | 14 | Current transfer count |
| dma_dir | output | 1 | Transfer direction flag |
| dma_en | output | 1 | DMA enable |
| dma_addr | output | 22 | Word-aligned target address |

## Verification
Two events can land on the same clock edge: the dummy-transfer increment from one count load, and a second count load. The bench provokes this by issuing two count writes back to back. It then requires the second value to appear unmodified on the next edge and to appear incremented by exactly one on the edge after that. If the first increment leaked through, or was applied to the new value, the sampled count would be off by one. The same sequence also checks that a read in the cycle just after a load shows the value before the increment.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   localparam int DEF_CNT_W    = 14;
   localparam int DEF_DA_W     = 22;
   localparam int DEF_SPLIT    = 9;
   localparam int DEF_HALF_BIT = 14;

   typedef enum logic {
      HALF_LOW  = 1'b0,
      HALF_HIGH = 1'b1
   } adr_half_e;
endpackage

// File: rtl/dma_cnt_reg.sv
module dma_cnt_reg #(
   parameter int CNT_W     = dma_regs_pkg::DEF_CNT_W,
   parameter bit DUMMY_INC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic [CNT_W+1:0] ld_word,
   output logic [CNT_W-1:0] cnt,
   output logic             dir,
   output logic             en
);
   logic [CNT_W-1:0] cnt_q;
   logic             dir_q;
   logic             en_q;
   logic             bump;

   generate
      if (DUMMY_INC) begin : g_dummy
         logic pend_q;
         always_ff @(posedge clk) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= ld;
         end
         assign bump = pend_q;
      end else begin : g_plain
         assign bump = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
         en_q  <= 1'b0;
      end else if (ld) begin
         {en_q, dir_q, cnt_q} <= ld_word;
      end else if (bump) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign cnt = cnt_q;
   assign dir = dir_q;
   assign en  = en_q;
endmodule

// File: rtl/dma_adr_reg.sv
module dma_adr_reg #(
   parameter int DA_W     = dma_regs_pkg::DEF_DA_W,
   parameter int SPLIT    = dma_regs_pkg::DEF_SPLIT,
   parameter int HALF_BIT = dma_regs_pkg::DEF_HALF_BIT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld,
   input  logic [HALF_BIT:1]   a,
   output logic [DA_W-1:0]     adr
);
   import dma_regs_pkg::*;
   localparam int HI_W = DA_W - SPLIT;
   localparam int LO_W = SPLIT - 1;

   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] lo_q;
   adr_half_e       half;

   assign half = adr_half_e'(a[HALF_BIT]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (ld) begin
         if (half == HALF_HIGH) hi_q <= a[HI_W:1];
         else                   lo_q <= a[LO_W:1];
      end
   end

   assign adr = {hi_q, lo_q, 1'b0};
endmodule

// File: rtl/dma_rd_mux.sv
module dma_rd_mux #(
   parameter int CNT_W = dma_regs_pkg::DEF_CNT_W
) (
   input  logic             sel_cnt,
   input  logic [CNT_W-1:0] cnt,
   output logic [CNT_W+1:0] rdata
);
   always_comb begin
      rdata = '1;
      if (sel_cnt) rdata[CNT_W-1:0] = cnt;
   end
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs #(
   parameter int CNT_W     = dma_regs_pkg::DEF_CNT_W,
   parameter int DA_W      = dma_regs_pkg::DEF_DA_W,
   parameter int SPLIT     = dma_regs_pkg::DEF_SPLIT,
   parameter int HALF_BIT  = dma_regs_pkg::DEF_HALF_BIT,
   parameter bit DUMMY_INC = 1'b1,
   localparam int DW       = CNT_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_sel_cnt,
   input  logic              bus_sel_adr,
   input  logic [HALF_BIT:1] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   output logic [CNT_W-1:0]  dma_count,
   output logic              dma_dir,
   output logic              dma_en,
   output logic [DA_W-1:0]   dma_addr
);
   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("dma_xfer_regs: CNT_W must be positive");
      end
      if (SPLIT < 2 || SPLIT >= DA_W) begin : g_bad_split
         $error("dma_xfer_regs: SPLIT must lie inside the address");
      end
      if (DA_W - SPLIT > HALF_BIT - 1 || SPLIT - 1 > HALF_BIT - 1) begin : g_bad_half
         $error("dma_xfer_regs: address lines too narrow for a half");
      end
   endgenerate

   logic ld_cnt;
   logic ld_adr;

   assign ld_cnt = bus_wr & bus_sel_cnt;
   assign ld_adr = bus_wr & bus_sel_adr;

   dma_cnt_reg #(.CNT_W(CNT_W), .DUMMY_INC(DUMMY_INC)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (ld_cnt),
      .ld_word (bus_wdata),
      .cnt     (dma_count),
      .dir     (dma_dir),
      .en      (dma_en)
   );

   dma_adr_reg #(.DA_W(DA_W), .SPLIT(SPLIT), .HALF_BIT(HALF_BIT)) adr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld_adr),
      .a     (bus_addr),
      .adr   (dma_addr)
   );

   dma_rd_mux #(.CNT_W(CNT_W)) rd_i (
      .sel_cnt (bus_sel_cnt),
      .cnt     (dma_count),
      .rdata   (bus_rdata)
   );
endmodule

// File: rtl/dma_xfer_regs_chk.sv
module dma_xfer_regs_chk #(
   parameter int CNT_W     = 14,
   parameter int DA_W      = 22,
   parameter int SPLIT     = 9,
   parameter int HALF_BIT  = 14,
   parameter bit DUMMY_INC = 1'b1,
   localparam int DW       = CNT_W + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_sel_cnt,
   input logic              bus_sel_adr,
   input logic [HALF_BIT:1] bus_addr,
   input logic [DW-1:0]     bus_wdata,
   input logic [DW-1:0]     bus_rdata,
   input logic [CNT_W-1:0]  dma_count,
   input logic              dma_dir,
   input logic              dma_en,
   input logic [DA_W-1:0]   dma_addr
);
   logic wc;
   logic wa;
   logic wc_d;
   assign wc = bus_wr & bus_sel_cnt;
   assign wa = bus_wr & bus_sel_adr;

   always_ff @(posedge clk) begin
      if (!rst_n) wc_d <= 1'b0;
      else        wc_d <= wc;
   end

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wc |=> (dma_count == $past(bus_wdata[CNT_W-1:0]))
             && (dma_dir == $past(bus_wdata[CNT_W]))
             && (dma_en == $past(bus_wdata[CNT_W+1])));

   generate
      if (DUMMY_INC) begin : g_inc_chk
         p_bump_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (wc_d && !wc) |=> (dma_count == $past(dma_count) + CNT_W'(1)));
      end
   endgenerate

   p_rd_view_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel_cnt |-> (bus_rdata[DW-1:DW-2] == 2'b11)
                      && (bus_rdata[CNT_W-1:0] == dma_count));

   p_hi_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wa && bus_addr[HALF_BIT]) |=>
         (dma_addr[DA_W-1:SPLIT] == $past(bus_addr[DA_W-SPLIT:1]))
         && $stable(dma_addr[SPLIT-1:0]));

   p_lo_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wa && !bus_addr[HALF_BIT]) |=>
         (dma_addr[SPLIT-1:1] == $past(bus_addr[SPLIT-1:1]))
         && $stable(dma_addr[DA_W-1:SPLIT]));

   p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wa |=> $stable(dma_addr));

   p_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_addr[0] == 1'b0);
endmodule

bind dma_xfer_regs dma_xfer_regs_chk #(
   .CNT_W(CNT_W), .DA_W(DA_W), .SPLIT(SPLIT),
   .HALF_BIT(HALF_BIT), .DUMMY_INC(DUMMY_INC)
) chk_i (.*);

// File: tb/dma_xfer_regs_tb_top.sv
module dma_xfer_regs_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_sel_cnt = 1'b0;
   logic        bus_sel_adr = 1'b0;
   logic [14:1] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [13:0] dma_count;
   logic        dma_dir;
   logic        dma_en;
   logic [21:0] dma_addr;

   int checks = 0;
   int errors = 0;
   logic [21:0] exp_adr = '0;

   always #10 clk = ~clk;

   dma_xfer_regs dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
      .bus_sel_cnt(bus_sel_cnt), .bus_sel_adr(bus_sel_adr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .dma_count(dma_count), .dma_dir(dma_dir), .dma_en(dma_en),
      .dma_addr(dma_addr)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      bus_wr = 1'b0; bus_sel_cnt = 1'b0; bus_sel_adr = 1'b0;
   endtask

   task automatic write_cnt(input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel_cnt = 1'b1; bus_sel_adr = 1'b0; bus_wdata = d;
   endtask

   task automatic write_adr(input logic [14:1] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel_cnt = 1'b0; bus_sel_adr = 1'b1;
      bus_addr = a; bus_wdata = d;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 count", 32'(dma_count), 32'h0);
      chk("R1 dir", 32'(dma_dir), 32'h0);
      chk("R1 en", 32'(dma_en), 32'h0);
      chk("R1 addr", 32'(dma_addr), 32'h0);
      chk("R9 idle rdata", 32'(bus_rdata), 32'hFFFF);
   endtask

   task automatic t_cnt_load();
      write_cnt(16'h8123);
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R2 count", 32'(dma_count), 32'h0123);
      chk("R2 en", 32'(dma_en), 32'h1);
      chk("R2 dir", 32'(dma_dir), 32'h0);
      chk("R5 read pre-bump", 32'(bus_rdata), 32'hC123);
      @(negedge clk);
      chk("R3 bump", 32'(dma_count), 32'h0124);
      chk("R5 read", 32'(bus_rdata), 32'hC124);
      @(negedge clk);
      chk("R3 hold", 32'(dma_count), 32'h0124);
      idle();
   endtask

   task automatic t_wrap();
      write_cnt(16'h7FFF);
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R2 max count", 32'(dma_count), 32'h3FFF);
      chk("R2 dir set", 32'(dma_dir), 32'h1);
      chk("R2 en clear", 32'(dma_en), 32'h0);
      @(negedge clk);
      chk("R3 wrap", 32'(dma_count), 32'h0000);
      chk("R5 read wrap", 32'(bus_rdata), 32'hC000);
      idle();
   endtask

   task automatic t_back2back();
      write_cnt(16'h0010);
      write_cnt(16'h4200);
      chk("R4 first", 32'(dma_count), 32'h0010);
      @(negedge clk);
      bus_wr = 1'b0;
      chk("R4 second unbumped", 32'(dma_count), 32'h0200);
      chk("R4 dir", 32'(dma_dir), 32'h1);
      @(negedge clk);
      chk("R4 second bumped", 32'(dma_count), 32'h0201);
      @(negedge clk);
      chk("R4 single bump", 32'(dma_count), 32'h0201);
      idle();
   endtask

   task automatic t_addr();
      logic [13:0] cnt_before;
      cnt_before = dma_count;
      write_adr({1'b1, 13'h1ABC}, 16'h5555);
      @(negedge clk);
      bus_wr = 1'b0;
      exp_adr = {13'h1ABC, 8'h00, 1'b0};
      chk("R6 high load", 32'(dma_addr), 32'(exp_adr));
      chk("R6 count untouched", 32'(dma_count), 32'(cnt_before));
      write_adr({1'b0, 5'h1F, 8'hA5}, 16'hFFFF);
      @(negedge clk);
      bus_wr = 1'b0;
      exp_adr = {13'h1ABC, 8'hA5, 1'b0};
      chk("R7 low load keeps high", 32'(dma_addr), 32'(exp_adr));
      write_adr({1'b1, 13'h0003}, 16'h0000);
      @(negedge clk);
      bus_wr = 1'b0;
      exp_adr = {13'h0003, 8'hA5, 1'b0};
      chk("R6 high load keeps low", 32'(dma_addr), 32'(exp_adr));
      chk("R8 lsb zero", 32'(dma_addr[0]), 32'h0);
      chk("R9 addr read ones", 32'(bus_rdata), 32'hFFFF);
      idle();
   endtask

   task automatic t_read_no_effect();
      logic [13:0] cnt_before;
      cnt_before = dma_count;
      @(negedge clk);
      bus_wr = 1'b0; bus_sel_adr = 1'b1; bus_sel_cnt = 1'b0;
      bus_addr = {1'b0, 13'h0000}; bus_wdata = 16'h1234;
      chk("R9 addr rdata", 32'(bus_rdata), 32'hFFFF);
      @(negedge clk);
      bus_sel_adr = 1'b0; bus_sel_cnt = 1'b1;
      @(negedge clk);
      chk("R9 addr unchanged", 32'(dma_addr), 32'(exp_adr));
      chk("R9 count unchanged", 32'(dma_count), 32'(cnt_before));
      idle();
   endtask

   initial begin
      t_reset();
      t_cnt_load();
      t_wrap();
      t_back2back();
      t_addr();
      t_read_no_effect();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired got running exp done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule